// File: doc/BRIEF.md
# Shared Last-Level Cache Bank with Tag-Resident Directory

This block is one bank of a last-level cache shared by several private L1 caches. Lines are spread across banks by address, so each bank serves only the lines whose bank-select bits equal its own index. The bank has no separate directory. Each tag entry also holds the coherence record for its line: an owner ID and a one-hot sharer vector over the L1 caches.

The bank handles the read-miss path only. An L1 read request (GETS) to a line that is not present allocates the entry in a transient state and sends a line fetch to memory. When the memory data returns, the bank forwards it as exclusive data to the requester, which is named by a one-hot destination vector. The line then stays blocked until that requester sends an unblock message, at which point the line becomes stable and owned by that requester. A request to a line that is not in the not-present state is held off with backpressure, while requests to other lines keep flowing. A counter records every fetch sent to memory. A combinational probe port exposes the directory record of any set.

Top module: `l2dir_bank`

## Requirements
- R1: A request whose address bits [7:6] differ from the bank index (default 1) sees `req_ready` low. It causes no fetch, no counter change and no directory change.
- R2: A request accepted on a clock edge for a not-present line moves that set to ISS (state code 1) with owner equal to `req_src`. On the following cycle it presents `mem_req_valid` with `mem_req_addr` equal to the request address with bits [5:0] cleared.
- R3: While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` stay unchanged. The fetch drops on the cycle after it is taken.
- R4: Memory data for a line in ISS (matching set and tag) produces, one cycle later, a single-cycle `excl_valid`. `excl_dst` has only bit `owner` set, and the pulse carries the data and the line address. The set moves to MT_MB (code 2).
- R5: In MT_MB, an unblock from the recorded owner moves the set to MT (code 3), with the owner unchanged and the sharer vector holding only the owner's bit. An unblock from any other source leaves the set in MT_MB.
- R6: A request to a set in ISS, MT_MB or MT sees `req_ready` low, while a request to a not-present set in the same cycle window is accepted.
- R7: `miss_count` increases by exactly one for each accepted request, one cycle after acceptance, and never otherwise.
- R8: Memory data for a line that is not in ISS produces no `excl_valid` and changes no directory state.
- R9: After reset every set reads not-present (code 0), `miss_count` is 0, and `mem_req_valid` and `excl_valid` are low.
- R10: A memory fill, an owner unblock and a new request aimed at three different sets in one cycle all take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | L1 read request present |
| req_ready | output | 1 | Bank takes the request this cycle |
| req_addr | input | 16 | Request byte address |
| req_src | input | 3 | Requesting L1 ID |
| excl_valid | output | 1 | Exclusive data response valid |
| excl_dst | output | 8 | One-hot destination L1 |
| excl_addr | output | 16 | Line address of the response |
| excl_data | output | 32 | Response data |
| unb_valid | input | 1 | Unblock message present |
| unb_addr | input | 16 | Unblock line address |
| unb_src | input | 3 | Sender of the unblock |
| mem_req_valid | output | 1 | Line fetch to memory |
| mem_req_ready | input | 1 | Memory takes the fetch |
| mem_req_addr | output | 16 | Fetched line address |
| mem_rsp_valid | input | 1 | Memory data return |
| mem_rsp_addr | input | 16 | Returned line address |
| mem_rsp_data | input | 32 | Returned data |
| miss_count | output | 16 | Number of fetches issued |
| prb_addr | input | 16 | Probe address (set select) |
| prb_state | output | 2 | Probed set state (0 NP, 1 ISS, 2 MT_MB, 3 MT) |
| prb_owner | output | 3 | Probed set owner |
| prb_sharers | output | 8 | Probed set sharer vector |

## Verification
The bank can accept a new read miss on the same edge that a memory fill completes for one line and an unblock retires another, because each of these three updates writes a different directory entry. The bench drives all three in one cycle, aimed at three separate sets. On the next cycle it judges the outcome: the fill appears as an exclusive response to the right one-hot destination, the unblocked set reads MT with a single sharer, and the new fetch and the counter step appear together. The other pairing it provokes is a fetch held under memory backpressure while a request to an already-busy line is refused and a request to a free line waits for the fetch slot.

// File: rtl/l2dir_pkg.sv
package l2dir_pkg;

   typedef enum logic [1:0] {
      ST_NP   = 2'd0,
      ST_ISS  = 2'd1,
      ST_MTMB = 2'd2,
      ST_MT   = 2'd3
   } line_state_e;

endpackage

// File: rtl/l2dir_addr_split.sv
module l2dir_addr_split #(
   parameter int ADDR_W  = 16,
   parameter int OFF_W   = 6,
   parameter int BANK_W  = 2,
   parameter int BANK_ID = 1,
   parameter int IDX_W   = 4,
   localparam int TAG_W  = ADDR_W - OFF_W - BANK_W - IDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag,
   output logic              home
);

   assign idx = addr[OFF_W+BANK_W +: IDX_W];
   assign tag = addr[ADDR_W-1 -: TAG_W];

   generate
      if (BANK_W == 0) begin : g_single_bank
         assign home = 1'b1;
      end else begin : g_interleaved
         localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);
         assign home = (addr[OFF_W +: BANK_W] == MY_BANK);
      end
   endgenerate

endmodule

// File: rtl/l2dir_miss_ctr.sv
module l2dir_miss_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else if (inc) count <= count + CNT_W'(1);
   end

   // R7: the counter moves by at most one per cycle
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((count - $past(count)) <= CNT_W'(1)));

endmodule

// File: rtl/l2dir_tag_dir.sv
module l2dir_tag_dir
   import l2dir_pkg::*;
#(
   parameter int SETS   = 16,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 4,
   parameter int NUM_L1 = 8,
   parameter int SRC_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [SRC_W-1:0]  alloc_src,
   input  logic              fill_vld,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic              unb_vld,
   input  logic [IDX_W-1:0]  unb_idx,
   input  logic [TAG_W-1:0]  unb_tag,
   input  logic [SRC_W-1:0]  unb_src,
   input  logic [IDX_W-1:0]  rq_idx,
   input  logic [IDX_W-1:0]  prb_idx,
   output line_state_e       rq_state,
   output logic              fill_hit,
   output logic [SRC_W-1:0]  fill_owner,
   output line_state_e       prb_state,
   output logic [SRC_W-1:0]  prb_owner,
   output logic [NUM_L1-1:0] prb_sharers
);

   line_state_e       state_q [SETS];
   logic [TAG_W-1:0]  tag_q   [SETS];
   logic [SRC_W-1:0]  owner_q [SETS];
   logic [NUM_L1-1:0] shr_q   [SETS];
   logic              unb_hit;

   assign rq_state    = state_q[rq_idx];
   assign prb_state   = state_q[prb_idx];
   assign prb_owner   = owner_q[prb_idx];
   assign prb_sharers = shr_q[prb_idx];
   assign fill_owner  = owner_q[fill_idx];

   assign fill_hit = fill_vld && (state_q[fill_idx] == ST_ISS)
                     && (tag_q[fill_idx] == fill_tag);
   assign unb_hit  = unb_vld && (state_q[unb_idx] == ST_MTMB)
                     && (tag_q[unb_idx] == unb_tag)
                     && (owner_q[unb_idx] == unb_src);

   // The three updates hit sets in different states, so never the same set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            state_q[s] <= ST_NP;
            tag_q[s]   <= '0;
            owner_q[s] <= '0;
            shr_q[s]   <= '0;
         end
      end else begin
         if (alloc_en) begin
            state_q[alloc_idx] <= ST_ISS;
            tag_q[alloc_idx]   <= alloc_tag;
            owner_q[alloc_idx] <= alloc_src;
            shr_q[alloc_idx]   <= '0;
         end
         if (fill_hit) state_q[fill_idx] <= ST_MTMB;
         if (unb_hit) begin
            state_q[unb_idx] <= ST_MT;
            shr_q[unb_idx]   <= NUM_L1'(1) << owner_q[unb_idx];
         end
      end
   end

   // R6: allocation only ever targets a not-present set
   p_alloc_free_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (state_q[alloc_idx] == ST_NP));

   // R4: a filled set is in MT_MB on the next cycle
   p_fill_to_mtmb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_hit && !alloc_en) |=> (state_q[$past(fill_idx)] == ST_MTMB));

endmodule

// File: rtl/l2dir_bank.sv
module l2dir_bank
   import l2dir_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int OFF_W   = 6,
   parameter int BANK_W  = 2,
   parameter int BANK_ID = 1,
   parameter int SETS    = 16,
   parameter int NUM_L1  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   localparam int IDX_W  = $clog2(SETS),
   localparam int SRC_W  = $clog2(NUM_L1),
   localparam int TAG_W  = ADDR_W - OFF_W - BANK_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SRC_W-1:0]  req_src,
   output logic              excl_valid,
   output logic [NUM_L1-1:0] excl_dst,
   output logic [ADDR_W-1:0] excl_addr,
   output logic [DATA_W-1:0] excl_data,
   input  logic              unb_valid,
   input  logic [ADDR_W-1:0] unb_addr,
   input  logic [SRC_W-1:0]  unb_src,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_addr,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic [CNT_W-1:0]  miss_count,
   input  logic [ADDR_W-1:0] prb_addr,
   output logic [1:0]        prb_state,
   output logic [SRC_W-1:0]  prb_owner,
   output logic [NUM_L1-1:0] prb_sharers
);

   // elaboration-time parameter checks
   generate
      if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
         $error("SETS must be a power of two, at least 2");
      end
      if (NUM_L1 < 2) begin : g_bad_l1
         $error("NUM_L1 must be at least 2");
      end
      if (OFF_W < 1) begin : g_bad_off
         $error("OFF_W must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("address too narrow for offset, bank and index fields");
      end
      if (BANK_W > 0 && BANK_ID >= (1 << BANK_W)) begin : g_bad_bank
         $error("BANK_ID does not fit in BANK_W bits");
      end
   endgenerate

   localparam int N_PORTS = 4;  // request, memory data, unblock, probe

   logic [ADDR_W-1:0] port_addr [N_PORTS];
   logic [IDX_W-1:0]  port_idx  [N_PORTS];
   logic [TAG_W-1:0]  port_tag  [N_PORTS];
   logic              port_home [N_PORTS];

   assign port_addr[0] = req_addr;
   assign port_addr[1] = mem_rsp_addr;
   assign port_addr[2] = unb_addr;
   assign port_addr[3] = prb_addr;

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_split
         l2dir_addr_split #(
            .ADDR_W (ADDR_W),
            .OFF_W  (OFF_W),
            .BANK_W (BANK_W),
            .BANK_ID(BANK_ID),
            .IDX_W  (IDX_W)
         ) u_split (
            .addr(port_addr[p]),
            .idx (port_idx[p]),
            .tag (port_tag[p]),
            .home(port_home[p])
         );
      end
   endgenerate

   line_state_e       rq_state;
   line_state_e       prb_state_e;
   logic              fill_hit;
   logic [SRC_W-1:0]  fill_owner;
   logic              slot_free;
   logic              accept;
   logic              fill_vld;
   logic              unb_vld;
   logic [ADDR_W-1:0] req_line;
   logic [ADDR_W-1:0] rsp_line;

   assign slot_free = !mem_req_valid || mem_req_ready;
   assign req_ready = port_home[0] && (rq_state == ST_NP) && slot_free;
   assign accept    = req_valid && req_ready;
   assign fill_vld  = mem_rsp_valid && port_home[1];
   assign unb_vld   = unb_valid && port_home[2];
   assign req_line  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign rsp_line  = {mem_rsp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign prb_state = prb_state_e;

   l2dir_tag_dir #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .NUM_L1(NUM_L1),
      .SRC_W (SRC_W)
   ) u_dir (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (accept),
      .alloc_idx  (port_idx[0]),
      .alloc_tag  (port_tag[0]),
      .alloc_src  (req_src),
      .fill_vld   (fill_vld),
      .fill_idx   (port_idx[1]),
      .fill_tag   (port_tag[1]),
      .unb_vld    (unb_vld),
      .unb_idx    (port_idx[2]),
      .unb_tag    (port_tag[2]),
      .unb_src    (unb_src),
      .rq_idx     (port_idx[0]),
      .prb_idx    (port_idx[3]),
      .rq_state   (rq_state),
      .fill_hit   (fill_hit),
      .fill_owner (fill_owner),
      .prb_state  (prb_state_e),
      .prb_owner  (prb_owner),
      .prb_sharers(prb_sharers)
   );

   // memory fetch slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req_valid <= 1'b0;
         mem_req_addr  <= '0;
      end else if (accept) begin
         mem_req_valid <= 1'b1;
         mem_req_addr  <= req_line;
      end else if (mem_req_ready) begin
         mem_req_valid <= 1'b0;
      end
   end

   // exclusive data response to the recorded requester
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         excl_valid <= 1'b0;
         excl_dst   <= '0;
         excl_addr  <= '0;
         excl_data  <= '0;
      end else begin
         excl_valid <= fill_hit;
         if (fill_hit) begin
            excl_dst  <= NUM_L1'(1) << fill_owner;
            excl_addr <= rsp_line;
            excl_data <= mem_rsp_data;
         end
      end
   end

   l2dir_miss_ctr #(.CNT_W(CNT_W)) u_miss (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (accept),
      .count(miss_count)
   );

   // R2: every accepted request yields a line-aligned fetch next cycle
   p_fetch_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req_valid && (mem_req_addr[OFF_W-1:0] == '0)));

   // R3: a stalled fetch holds its address
   p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R4: the response goes to exactly one L1
   p_resp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      excl_valid |-> ($countones(excl_dst) == 1));

   // R5: a stable owned line has a single sharer, the owner
   p_mt_single_sharer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_state == 2'd3) |-> (($countones(prb_sharers) == 1) && prb_sharers[prb_owner]));

   // R1: a foreign-bank request never enters the fetch path
   p_foreign_no_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !port_home[0] && !mem_req_valid) |=> !mem_req_valid);

endmodule

// File: tb/l2dir_bank_test.sv
`timescale 1ns/1ps
module l2dir_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [2:0]  req_src = '0;
   logic        excl_valid;
   logic [7:0]  excl_dst;
   logic [15:0] excl_addr;
   logic [31:0] excl_data;
   logic        unb_valid = 1'b0;
   logic [15:0] unb_addr = '0;
   logic [2:0]  unb_src = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [15:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_addr = '0;
   logic [31:0] mem_rsp_data = '0;
   logic [15:0] miss_count;
   logic [15:0] prb_addr = '0;
   logic [1:0]  prb_state;
   logic [2:0]  prb_owner;
   logic [7:0]  prb_sharers;

   int n_run  = 0;
   int n_fail = 0;
   int exp_miss = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   l2dir_bank uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_src(req_src),
      .excl_valid(excl_valid), .excl_dst(excl_dst), .excl_addr(excl_addr), .excl_data(excl_data),
      .unb_valid(unb_valid), .unb_addr(unb_addr), .unb_src(unb_src),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data),
      .miss_count(miss_count),
      .prb_addr(prb_addr), .prb_state(prb_state), .prb_owner(prb_owner), .prb_sharers(prb_sharers)
   );

   // address: tag [15:12], set [11:8], bank [7:6], offset [5:0]
   function automatic logic [15:0] mk(input logic [3:0] tg, input logic [3:0] st,
                                      input logic [1:0] bk, input logic [5:0] off);
      return {tg, st, bk, off};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic probe(input logic [15:0] a);
      prb_addr = a;
      #0.5;
   endtask

   // vector: tag[47:44] set[43:40] src[39:36] off[35:32] data[31:0]
   localparam logic [47:0] VEC [6] = '{
      48'h1_0_4_3_DEAD0001,
      48'h2_1_1_0_CAFE0002,
      48'h3_2_0_F_12345678,
      48'h4_3_7_8_A5A5A5A5,
      48'h5_4_2_1_0F0F0F0F,
      48'hF_5_6_C_FFFF0000
   };

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check("R9 miss_count", 64'(miss_count), 64'd0);
      check("R9 mem_req_valid", 64'(mem_req_valid), 64'd0);
      check("R9 excl_valid", 64'(excl_valid), 64'd0);
      probe(mk(4'h0, 4'd9, 2'd1, 6'd0));
      check("R9 set state NP", 64'(prb_state), 64'd0);
      rst_n = 1'b1;
      tick();

      // table walk: full read-miss and exclusive-grant flow
      for (int i = 0; i < 6; i++) begin
         automatic logic [3:0]  tg  = VEC[i][47:44];
         automatic logic [3:0]  st  = VEC[i][43:40];
         automatic logic [2:0]  src = VEC[i][38:36];
         automatic logic [5:0]  off = {2'b00, VEC[i][35:32]} << 2;
         automatic logic [31:0] dat = VEC[i][31:0];
         automatic logic [15:0] a   = mk(tg, st, 2'd1, off);
         automatic logic [15:0] ln  = mk(tg, st, 2'd1, 6'd0);
         req_valid = 1'b1; req_addr = a; req_src = src;
         #0.5;
         check("R2 ready on NP line", 64'(req_ready), 64'd1);
         tick();
         req_valid = 1'b0;
         exp_miss++;
         check("R2 fetch valid", 64'(mem_req_valid), 64'd1);
         check("R2 fetch line address", 64'(mem_req_addr), 64'(ln));
         check("R7 miss count step", 64'(miss_count), 64'(exp_miss));
         probe(a);
         check("R2 state ISS", 64'(prb_state), 64'd1);
         check("R2 owner", 64'(prb_owner), 64'(src));
         mem_rsp_valid = 1'b1; mem_rsp_addr = ln; mem_rsp_data = dat;
         tick();
         mem_rsp_valid = 1'b0;
         check("R4 excl_valid", 64'(excl_valid), 64'd1);
         check("R4 excl_dst one-hot", 64'(excl_dst), 64'(8'd1 << src));
         check("R4 excl_data", 64'(excl_data), 64'(dat));
         check("R4 excl_addr", 64'(excl_addr), 64'(ln));
         check("R4 state MT_MB", 64'(prb_state), 64'd2);
         check("R3 fetch dropped after take", 64'(mem_req_valid), 64'd0);
         unb_valid = 1'b1; unb_addr = ln; unb_src = src;
         tick();
         unb_valid = 1'b0;
         check("R4 single-cycle pulse", 64'(excl_valid), 64'd0);
         check("R5 state MT", 64'(prb_state), 64'd3);
         check("R5 sharers only owner", 64'(prb_sharers), 64'(8'd1 << src));
         check("R5 owner kept", 64'(prb_owner), 64'(src));
      end

      // R1: foreign bank
      req_valid = 1'b1; req_addr = mk(4'h7, 4'd10, 2'd2, 6'd0); req_src = 3'd1;
      #0.5;
      check("R1 foreign ready low", 64'(req_ready), 64'd0);
      tick();
      req_valid = 1'b0;
      check("R1 no fetch", 64'(mem_req_valid), 64'd0);
      check("R1 counter unchanged", 64'(miss_count), 64'(exp_miss));
      probe(mk(4'h7, 4'd10, 2'd1, 6'd0));
      check("R1 set stays NP", 64'(prb_state), 64'd0);

      // R3: fetch held under memory backpressure
      mem_req_ready = 1'b0;
      req_valid = 1'b1; req_addr = mk(4'h8, 4'd8, 2'd1, 6'd20); req_src = 3'd2;
      tick();
      req_valid = 1'b0;
      exp_miss++;
      tick(); tick();
      check("R3 fetch held", 64'(mem_req_valid), 64'd1);
      check("R3 address held", 64'(mem_req_addr), 64'(mk(4'h8, 4'd8, 2'd1, 6'd0)));
      // R6: a free line must wait for the fetch slot, a busy line is refused
      req_valid = 1'b1; req_addr = mk(4'h8, 4'd8, 2'd1, 6'd0); req_src = 3'd3;
      #0.5;
      check("R6 ISS line refused", 64'(req_ready), 64'd0);
      req_addr = mk(4'h9, 4'd11, 2'd1, 6'd4); req_src = 3'd5;
      #0.5;
      check("R3 slot busy holds free line", 64'(req_ready), 64'd0);
      mem_req_ready = 1'b1;
      #0.5;
      check("R6 free line accepted", 64'(req_ready), 64'd1);
      tick();
      req_valid = 1'b0;
      exp_miss++;
      check("R7 count after two misses", 64'(miss_count), 64'(exp_miss));
      check("R2 next fetch address", 64'(mem_req_addr), 64'(mk(4'h9, 4'd11, 2'd1, 6'd0)));
      tick();

      // R8: stray memory data, to a NP set and to an MT set
      mem_rsp_valid = 1'b1; mem_rsp_addr = mk(4'h3, 4'd12, 2'd1, 6'd0); mem_rsp_data = 32'h11111111;
      tick();
      check("R8 no response for NP line", 64'(excl_valid), 64'd0);
      mem_rsp_addr = mk(4'h1, 4'd0, 2'd1, 6'd0);
      tick();
      mem_rsp_valid = 1'b0;
      check("R8 no response for MT line", 64'(excl_valid), 64'd0);
      probe(mk(4'h1, 4'd0, 2'd1, 6'd0));
      check("R8 MT line unchanged", 64'(prb_state), 64'd3);
      probe(mk(4'h3, 4'd12, 2'd1, 6'd0));
      check("R8 NP line unchanged", 64'(prb_state), 64'd0);

      // fill set 8 then a wrong-source unblock
      mem_rsp_valid = 1'b1; mem_rsp_addr = mk(4'h8, 4'd8, 2'd1, 6'd0); mem_rsp_data = 32'h88880008;
      tick();
      mem_rsp_valid = 1'b0;
      check("R4 dst requester 2", 64'(excl_dst), 64'h04);
      unb_valid = 1'b1; unb_addr = mk(4'h8, 4'd8, 2'd1, 6'd0); unb_src = 3'd3;
      tick();
      unb_valid = 1'b0;
      probe(mk(4'h8, 4'd8, 2'd1, 6'd0));
      check("R5 wrong source ignored", 64'(prb_state), 64'd2);
      req_valid = 1'b1; req_addr = mk(4'h8, 4'd8, 2'd1, 6'd0); req_src = 3'd0;
      #0.5;
      check("R6 MT_MB line refused", 64'(req_ready), 64'd0);
      req_addr = mk(4'h1, 4'd0, 2'd1, 6'd0);
      #0.5;
      check("R6 MT line refused", 64'(req_ready), 64'd0);
      req_valid = 1'b0;

      // R10: fill, unblock and new request to three sets in one cycle
      unb_valid = 1'b1; unb_addr = mk(4'h8, 4'd8, 2'd1, 6'd0); unb_src = 3'd2;
      mem_rsp_valid = 1'b1; mem_rsp_addr = mk(4'h9, 4'd11, 2'd1, 6'd0); mem_rsp_data = 32'hB0B0000B;
      req_valid = 1'b1; req_addr = mk(4'hA, 4'd13, 2'd1, 6'd0); req_src = 3'd6;
      #0.5;
      check("R10 request accepted alongside", 64'(req_ready), 64'd1);
      tick();
      unb_valid = 1'b0; mem_rsp_valid = 1'b0; req_valid = 1'b0;
      exp_miss++;
      check("R10 fill response valid", 64'(excl_valid), 64'd1);
      check("R10 fill dst requester 5", 64'(excl_dst), 64'h20);
      check("R10 fill data", 64'(excl_data), 64'h B0B0000B);
      check("R10 new fetch", 64'(mem_req_addr), 64'(mk(4'hA, 4'd13, 2'd1, 6'd0)));
      check("R10 counter", 64'(miss_count), 64'(exp_miss));
      probe(mk(4'h8, 4'd8, 2'd1, 6'd0));
      check("R10 unblocked set MT", 64'(prb_state), 64'd3);
      check("R10 sharers", 64'(prb_sharers), 64'h04);
      probe(mk(4'h9, 4'd11, 2'd1, 6'd0));
      check("R10 filled set MT_MB", 64'(prb_state), 64'd2);
      probe(mk(4'hA, 4'd13, 2'd1, 6'd0));
      check("R10 new set ISS", 64'(prb_state), 64'd1);
      tick();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule